// File: doc/BRIEF.md
# Pipeline Load-Use Interlock Unit

This unit watches the instruction sitting in decode of a five-stage in-order pipeline with eight architectural registers and decides whether it may advance. It compares the registers the decoding instruction reads against the register written by each older instruction still in flight in execute and memory. On a read-after-write conflict it freezes the program counter and the fetch/decode register and injects a bubble into the decode/execute register.

The destination of an older instruction is not at a fixed place: arithmetic instructions name it in the low field and loads name it in the middle field, so the unit picks the field per opcode. A parameter selects between two policies. With `FORWARD_EN = 0` the datapath has no bypass network and every dependence on an in-flight producer stalls. With `FORWARD_EN = 1` results are bypassed, and only a load followed directly by a consumer of the loaded register stalls. The unit holds no state: its controls follow the current pipeline-register contents within the same cycle.

Top module: `raw_interlock`

## Requirements
- R1: Opcodes are 3 bits: add=0, nand=1, load=2, store=3, branch=4, jump-and-link=5, halt=6, noop=7. Register fields are 3 bits. Each older stage supplies its middle field (`*_fld_hi`, instruction bits 18:16) and its low field (`*_fld_lo`, bits 2:0).
- R2: In stall mode, the unit stalls when a source read by decode equals the destination of an add or nand in execute.
- R3: In stall mode, the unit also stalls when a source matches a producer in memory. A consumer directly behind an ALU producer therefore sees two stalled cycles and then proceeds once the producer leaves memory.
- R4: While stalled, `pc_en`=0, `ifid_en`=0 and `idex_bubble`=1. Otherwise `pc_en`=1, `ifid_en`=1 and `idex_bubble`=0. A pipeline holding only noops does not stall.
- R5: A load's destination is its middle field, and its low field is ignored. An add or nand's destination is its low field.
- R6: Decode reads both sources for add, nand, store and branch, only the first source for a load, and nothing for jump-and-link, halt and noop.
- R7: Store, branch, jump-and-link, halt and noop in execute or memory never count as producers.
- R8: Register 0 is compared like any other register.
- R9: In forwarding mode, a load in execute whose destination is read by decode stalls. A load in memory never stalls.
- R10: In forwarding mode, add and nand producers in execute or memory never stall.
- R11: The controls are combinational. They reflect the inputs of the current cycle with no dependence on earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 3 | Opcode of the instruction in decode |
| dec_srca | input | 3 | First source register field in decode |
| dec_srcb | input | 3 | Second source register field in decode |
| ex_op | input | 3 | Opcode of the instruction in execute |
| ex_fld_hi | input | 3 | Middle register field (bits 18:16) in execute |
| ex_fld_lo | input | 3 | Low register field (bits 2:0) in execute |
| mem_op | input | 3 | Opcode of the instruction in memory |
| mem_fld_hi | input | 3 | Middle register field in memory |
| mem_fld_lo | input | 3 | Low register field in memory |
| pc_en | output | 1 | Program counter update enable |
| ifid_en | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Write a noop into the decode/execute register |

## Verification
The execute-stage and memory-stage hazard checks can fire in the same cycle. The bench provokes this by giving the two sources of one consumer separate producers, one in each stage. In stall mode the result must be a single stall. In forwarding mode it must be a stall only when the execute-stage producer is a load. Both policies are instantiated side by side and driven with identical vectors, so each case is judged against the expected stall of each mode.

// File: rtl/ilk_pkg.sv
// Shared encodings for the load-use interlock.
// Assumes 3-bit opcodes and eight architectural registers.
package ilk_pkg;
    localparam int unsigned OP_W    = 3;
    localparam int unsigned REG_W   = 3;
    localparam int unsigned N_SRC   = 2;
    localparam int unsigned N_OLDER = 2;   // execute, memory

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_JALR = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } op_e;

    // Sources read by the decoding instruction
    typedef struct packed {
        logic [N_SRC-1:0]            rd;
        logic [N_SRC-1:0][REG_W-1:0] src;
    } src_req_t;

    // Register written by an older instruction
    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] dst;
    } dst_t;
endpackage

// File: rtl/ilk_reader.sv
// Decides which source fields the decoding instruction actually reads.
// Assumes loads use their middle field as a destination, not a source.
module ilk_reader
    import ilk_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [REG_W-1:0] srca,
    input  logic [REG_W-1:0] srcb,
    output src_req_t         req
);
    // Per-opcode read mask for the two source fields
    always_comb begin
        req.src[0] = srca;
        req.src[1] = srcb;
        unique case (op_e'(op))
            OP_ADD, OP_NAND, OP_SW, OP_BEQ: req.rd = 2'b11;
            OP_LW:                          req.rd = 2'b01;
            default:                        req.rd = 2'b00;
        endcase
    end
endmodule

// File: rtl/ilk_writer.sv
// Extracts the destination of an older instruction, choosing the field by opcode.
// Assumes only add, nand and load write the register file.
module ilk_writer
    import ilk_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [REG_W-1:0] fld_hi,
    input  logic [REG_W-1:0] fld_lo,
    output dst_t             dst
);
    // Per-opcode destination field mux and producer flag
    always_comb begin
        unique case (op_e'(op))
            OP_ADD, OP_NAND: begin dst.wr = 1'b1; dst.dst = fld_lo; end
            OP_LW:           begin dst.wr = 1'b1; dst.dst = fld_hi; end
            default:         begin dst.wr = 1'b0; dst.dst = fld_lo; end
        endcase
    end
endmodule

// File: rtl/ilk_match.sv
// Compares each read source against one producer destination.
// Assumes register 0 is an ordinary register (no zero-register exemption).
module ilk_match
    import ilk_pkg::*;
(
    input  src_req_t req,
    input  dst_t     dst,
    output logic     hit
);
    logic [N_SRC-1:0] eq;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // One equality comparator per read source
        assign eq[i] = req.rd[i] && (req.src[i] == dst.dst);
    end

    // Any read source matching a live producer
    assign hit = dst.wr && (|eq);
endmodule

// File: rtl/raw_interlock.sv
// Read-after-write interlock for decode. Produces PC/IF-ID hold and an ID/EX bubble.
// FORWARD_EN=0: stall on any in-flight producer. FORWARD_EN=1: stall only on a
// load in execute feeding decode. Writeback is assumed to write before decode reads.
module raw_interlock
    import ilk_pkg::*;
#(
    parameter bit FORWARD_EN = 1'b0
) (
    input  logic [OP_W-1:0]  dec_op,
    input  logic [REG_W-1:0] dec_srca,
    input  logic [REG_W-1:0] dec_srcb,
    input  logic [OP_W-1:0]  ex_op,
    input  logic [REG_W-1:0] ex_fld_hi,
    input  logic [REG_W-1:0] ex_fld_lo,
    input  logic [OP_W-1:0]  mem_op,
    input  logic [REG_W-1:0] mem_fld_hi,
    input  logic [REG_W-1:0] mem_fld_lo,
    output logic             pc_en,
    output logic             ifid_en,
    output logic             idex_bubble
);
    src_req_t             dec_req;
    logic [OP_W-1:0]      st_op  [N_OLDER];
    logic [REG_W-1:0]     st_hi  [N_OLDER];
    logic [REG_W-1:0]     st_lo  [N_OLDER];
    dst_t                 st_dst [N_OLDER];
    logic [N_OLDER-1:0]   st_hit;
    logic                 stall;

    assign st_op[0] = ex_op;   assign st_hi[0] = ex_fld_hi;  assign st_lo[0] = ex_fld_lo;
    assign st_op[1] = mem_op;  assign st_hi[1] = mem_fld_hi; assign st_lo[1] = mem_fld_lo;

    ilk_reader u_reader (
        .op   (dec_op),
        .srca (dec_srca),
        .srcb (dec_srcb),
        .req  (dec_req)
    );

    for (genvar s = 0; s < N_OLDER; s++) begin : g_stage
        ilk_writer u_writer (
            .op     (st_op[s]),
            .fld_hi (st_hi[s]),
            .fld_lo (st_lo[s]),
            .dst    (st_dst[s])
        );

        ilk_match u_match (
            .req (dec_req),
            .dst (st_dst[s]),
            .hit (st_hit[s])
        );

        // Non-writing opcodes must not present a producer
        always_comb begin
            if (st_op[s] inside {OP_SW, OP_BEQ, OP_JALR, OP_HALT, OP_NOOP})
                a_r7_nonproducer_silent: assert (!st_dst[s].wr)
                    else $error("R7: stage %0d non-writer flagged as producer", s);
        end
    end

    if (FORWARD_EN) begin : g_fwd
        // Only a load still in execute cannot be bypassed in time
        assign stall = st_hit[0] && (ex_op == OP_LW);

        // Stalls in this mode originate only from a load in execute
        always_comb begin
            if (stall)
                a_r9_fwd_load_only: assert (ex_op == OP_LW && mem_op inside {[0:7]})
                    else $error("R9: forwarding stall without a load in execute");
            if (ex_op inside {OP_ADD, OP_NAND})
                a_r10_fwd_alu_free: assert (!idex_bubble)
                    else $error("R10: ALU producer caused a stall with forwarding");
        end
    end else begin : g_stall
        // Every in-flight producer that matches forces a stall
        assign stall = |st_hit;
    end

    // Hold the front end and inject a bubble while stalled
    assign pc_en       = !stall;
    assign ifid_en     = !stall;
    assign idex_bubble = stall;

    // A decode slot that reads nothing never stalls
    always_comb begin
        if (dec_op inside {OP_JALR, OP_HALT, OP_NOOP})
            a_r6_idle_decode_no_stall: assert (pc_en && !idex_bubble)
                else $error("R6: non-reading decode instruction stalled");
        if (!(ex_op inside {OP_ADD, OP_NAND, OP_LW}) && !(mem_op inside {OP_ADD, OP_NAND, OP_LW}))
            a_r4_no_producer_runs: assert (pc_en && ifid_en && !idex_bubble)
                else $error("R4: stall with no producer in flight");
    end
endmodule

// File: tb/raw_interlock_tb.sv
module raw_interlock_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int n_run  = 0;
    int n_fail = 0;

    logic [2:0] dop, da, db, eop, eb, ed, mop, mb, md;
    logic s_pc, s_ifid, s_bub, f_pc, f_ifid, f_bub;

    raw_interlock #(.FORWARD_EN(1'b0)) u_dut (
        .dec_op(dop), .dec_srca(da), .dec_srcb(db),
        .ex_op(eop), .ex_fld_hi(eb), .ex_fld_lo(ed),
        .mem_op(mop), .mem_fld_hi(mb), .mem_fld_lo(md),
        .pc_en(s_pc), .ifid_en(s_ifid), .idex_bubble(s_bub)
    );

    raw_interlock #(.FORWARD_EN(1'b1)) u_dut_fwd (
        .dec_op(dop), .dec_srca(da), .dec_srcb(db),
        .ex_op(eop), .ex_fld_hi(eb), .ex_fld_lo(ed),
        .mem_op(mop), .mem_fld_hi(mb), .mem_fld_lo(md),
        .pc_en(f_pc), .ifid_en(f_ifid), .idex_bubble(f_bub)
    );

    typedef struct packed {
        logic [2:0] dop, da, db, eop, eb, ed, mop, mb, md;
        logic       s_exp;
        logic       f_exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    // Opcodes per R1: add0 nand1 lw2 sw3 beq4 jalr5 halt6 noop7
    // Fields: dop da db | eop eb(hi) ed(lo) | mop mb md | stall fwd | req
    localparam vec_t VECS [NV] = '{
        '{7,0,0, 7,0,0, 7,0,0, 0,0, 4},   // R4 idle pipeline
        '{0,3,4, 0,1,3, 7,0,0, 1,0, 2},   // R2 add in ex, R10 no fwd stall
        '{0,1,3, 7,0,0, 1,2,3, 1,0, 3},   // R3 nand in mem
        '{0,1,2, 0,5,3, 1,6,4, 0,0, 1},   // R1 low field is ALU dest, no match
        '{0,3,5, 2,3,5, 7,0,0, 1,1, 9},   // R9 load in ex feeds decode
        '{0,5,6, 2,3,5, 7,0,0, 0,0, 5},   // R5 load low field ignored
        '{0,3,1, 7,0,0, 2,3,0, 1,0, 9},   // R9 load in mem: fwd no stall
        '{2,1,3, 0,0,3, 7,0,0, 0,0, 6},   // R6 load does not read second field
        '{2,3,1, 0,0,3, 7,0,0, 1,0, 6},   // R6 load reads base
        '{3,1,3, 2,3,0, 7,0,0, 1,1, 6},   // R6 store data read
        '{4,2,3, 0,0,3, 7,0,0, 1,0, 6},   // R6 branch reads both
        '{6,3,3, 0,0,3, 7,0,0, 0,0, 6},   // R6 halt reads nothing
        '{7,3,3, 2,3,3, 7,0,0, 0,0, 6},   // R6 noop reads nothing
        '{0,3,3, 3,3,3, 4,3,3, 0,0, 7},   // R7 store/branch not producers
        '{0,3,3, 6,3,3, 7,3,3, 0,0, 7},   // R7 halt/noop not producers
        '{0,3,3, 5,3,3, 7,0,0, 0,0, 7},   // R7 jump-and-link not producer
        '{0,0,0, 0,0,0, 7,0,0, 1,0, 8},   // R8 register 0 via add
        '{0,0,1, 2,0,0, 7,0,0, 1,1, 8},   // R8 register 0 via load
        '{0,2,4, 0,0,2, 1,0,4, 1,0, 3},   // R3 both stages hit at once
        '{0,2,4, 2,4,0, 2,2,0, 1,1, 9},   // R9 load ex + load mem together
        '{0,7,6, 2,6,0, 7,0,0, 1,1, 9},   // R9 second source hits load
        '{1,4,4, 1,0,4, 7,0,0, 1,0, 10}   // R10 nand-to-nand
    };

    task automatic drive(input vec_t v);
        dop = v.dop; da = v.da; db = v.db;
        eop = v.eop; eb = v.eb; ed = v.ed;
        mop = v.mop; mb = v.mb; md = v.md;
    endtask

    task automatic chk(input string req, input string tag, input logic pc,
                       input logic ifid, input logic bub, input logic exp_s);
        n_run++;
        if (pc !== !exp_s || ifid !== !exp_s || bub !== exp_s) begin
            n_fail++;
            $display("FAIL %s %s: got pc_en=%b ifid_en=%b bubble=%b, expected pc_en=%b ifid_en=%b bubble=%b",
                     req, tag, pc, ifid, bub, !exp_s, !exp_s, exp_s);
        end
    endtask

    task automatic step(input vec_t v, input string req, input string tag,
                        input logic s_e, input logic f_e);
        @(negedge clk);
        drive(v);
        #2;
        chk(req, {tag, " stall-mode"}, s_pc, s_ifid, s_bub, s_e);
        chk(req, {tag, " fwd-mode"},   f_pc, f_ifid, f_bub, f_e);
    endtask

    localparam vec_t IDLE = '{7,0,0, 7,0,0, 7,0,0, 0,0, 4};

    initial begin
        drive(IDLE);
        repeat (3) @(posedge clk);
        // R4: pipeline after reset holds only noops
        step(IDLE, "R4", "reset idle", 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            step(VECS[i], $sformatf("R%0d", VECS[i].req), $sformatf("vec %0d", i),
                 VECS[i].s_exp, VECS[i].f_exp);

        // R3: add moving ex -> mem -> wb; consumer waits in decode
        step('{0,3,0, 0,0,3, 7,0,0, 0,0, 3}, "R3", "seq add in ex",  1'b1, 1'b0);
        step('{0,3,0, 7,0,0, 0,0,3, 0,0, 3}, "R3", "seq add in mem", 1'b1, 1'b0);
        step('{0,3,0, 7,0,0, 7,0,0, 0,0, 3}, "R3", "seq add in wb",  1'b0, 1'b0);

        // R9: load moving ex -> mem; one bubble with forwarding
        step('{0,0,5, 2,5,0, 7,0,0, 0,0, 9}, "R9", "seq load in ex",  1'b1, 1'b1);
        step('{0,0,5, 7,0,0, 2,5,0, 0,0, 9}, "R9", "seq load in mem", 1'b1, 1'b0);

        // R11: no history; a hazard vector then idle clears within the cycle
        step(VECS[4], "R11", "hazard", 1'b1, 1'b1);
        @(negedge clk);
        drive(IDLE);
        #1;
        chk("R11", "same-cycle clear stall-mode", s_pc, s_ifid, s_bub, 1'b0);
        chk("R11", "same-cycle clear fwd-mode",   f_pc, f_ifid, f_bub, 1'b0);
        step(VECS[1], "R11", "repeat vec 1", 1'b1, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got running, expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule